// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a single-port synchronous static RAM that accepts one command per clock. A command is an address plus a read/write select, captured on a rising edge. The data for that command crosses the bus two edges later, for reads and for writes alike. Because every command uses the same fixed distance, reads and writes can be interleaved in any order with no idle bus cycle between them. The shared 36-bit data bus is modelled as three separate signals: input data, output data and an output-drive enable.

A load/advance control either loads a fresh external address or steps an internal 2-bit burst counter. Each burst covers four words. A static order input selects whether the burst runs in linear or interleaved order. Three chip-select inputs gate new loads. An active-low clock enable freezes the whole pipeline. An asynchronous output-enable pin can silence the data drivers at any moment. Four byte-lane write enables, each covering 9 bits, allow partial-word writes. The memory depth follows from an address-width parameter.

Top module: `zbt_sram`

## Requirements
- R1: A read command sampled at edge k (with `cen_n` low at edge k, edge k+1 and edge k+2) places the addressed word on `dq_out` with `dq_oe` high for exactly the one cycle that follows edge k+2.
- R2: A write command sampled at edge k takes `dq_in` at edge k+2. Lane j (bits 9j+8 down to 9j) is written only if `bwe_n[j]` was low when the command was sampled; the other lanes keep their contents.
- R3: Reads and writes may follow each other on consecutive edges in any order. A read always returns the most recent data written to its address, including a write issued on the edge just before it.
- R4: While `cen_n` is high at an edge, all inputs are ignored and every register keeps its value, including commands in flight and the bus outputs.
- R5: A load edge (`adv_ld` low) while any chip select is inactive starts no operation and ends any burst. The chip selects are `ce1_n` (active when low), `ce2` (active when high) and `ce3_n` (active when low). Commands already issued still complete.
- R6: An edge with `adv_ld` high while a burst is active issues the next beat, keeping the read/write type of the load. Address bits above bit 1 keep the loaded value. The low two bits become base+n modulo 4 when `burst_lin` is 1, or base XOR n when `burst_lin` is 0, where n counts the advances. `bwe_n` is sampled on every beat. With no burst active, an advance issues nothing.
- R7: `oe_n` high forces `dq_oe` low without waiting for a clock edge and does not disturb the data held in the output register.
- R8: After reset `dq_oe` is low, no burst is active and no command is in flight.
- R9: `dq_oe` is low in the cycle after edge k+2 whenever the command at edge k was a write or no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cen_n | input | 1 | Clock enable, active low; high freezes the block |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| rd_wr_n | input | 1 | 1 read, 0 write (sampled on load) |
| bwe_n | input | LANES | Byte-lane write enables, active low |
| burst_lin | input | 1 | 1 linear burst order, 0 interleaved |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data from the output register |
| dq_oe | output | 1 | Drive enable for the shared bus |

## Verification
On every clock, the embedded assertions check the following. A read in the last pipeline stage launches the bus, and a write there releases it. A stalled edge leaves the pipeline and the output register untouched. A deselected load ends the burst, and every advance steps the beat counter by one. Only the bench's scenarios can show the rest, because each of these depends on data and ordering across several commands. This covers the values returned after partial-lane writes and the forwarding when a read follows a write to the same word. It also covers the exact linear and interleaved address orders, and the asynchronous effect of the output enable.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_ADD = 1'b1
  } beat_order_e;

  // low two address bits of beat n in a four-word burst
  function automatic logic [1:0] beat_offset(input logic [1:0] base,
                                             input logic [1:0] n,
                                             input beat_order_e ord);
    logic [1:0] r;
    if (ord == ORD_ADD) r = base + n;
    else                r = base ^ n;
    return r;
  endfunction

endpackage

// File: rtl/zbt_burst.sv
`timescale 1ns/1ps
module zbt_burst
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              adv,
  input  logic              sel,
  input  logic              rd_in,
  input  logic [LANES-1:0]  be_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              linear,
  output logic              cmd_vld,
  output logic              cmd_rd,
  output logic [LANES-1:0]  cmd_be,
  output logic [ADDR_W-1:0] cmd_addr
);

  logic              active_q, active_n;
  logic              rd_q, rd_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [1:0]        cnt_q, cnt_n;
  beat_order_e       ord;

  assign ord = linear ? ORD_ADD : ORD_XOR;

  always_comb begin
    active_n = active_q;
    rd_n     = rd_q;
    base_n   = base_q;
    cnt_n    = cnt_q;
    cmd_vld  = 1'b0;
    cmd_rd   = 1'b0;
    cmd_addr = '0;
    cmd_be   = be_in;
    if (!adv) begin
      if (sel) begin
        active_n = 1'b1;
        rd_n     = rd_in;
        base_n   = addr_in;
        cnt_n    = 2'd0;
        cmd_vld  = 1'b1;
        cmd_rd   = rd_in;
        cmd_addr = addr_in;
      end else begin
        active_n = 1'b0;
      end
    end else if (active_q) begin
      cnt_n    = cnt_q + 2'd1;
      cmd_vld  = 1'b1;
      cmd_rd   = rd_q;
      cmd_addr = {base_q[ADDR_W-1:2], beat_offset(base_q[1:0], cnt_n, ord)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      base_q   <= '0;
      cnt_q    <= 2'd0;
    end else if (ce) begin
      active_q <= active_n;
      rd_q     <= rd_n;
      base_q   <= base_n;
      cnt_q    <= cnt_n;
    end
  end

  AST_DESEL_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !adv && !sel) |=> !active_q); // R5

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && adv && active_q) |=> (active_q && cnt_q == $past(cnt_q) + 2'd1)); // R6

  AST_STALL_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(active_q) && $stable(cnt_q) && $stable(base_q))); // R4

endmodule

// File: rtl/zbt_lane_ram.sv
`timescale 1ns/1ps
module zbt_lane_ram #(
  parameter int ADDR_W = 8,
  parameter int W      = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_n;
  logic         fwd;

  // a write committing on the same edge as this read wins over the array
  assign fwd     = we && (waddr == raddr);
  assign rdata_n = fwd ? wdata : mem[raddr];

  always_ff @(posedge clk) begin
    if (ce && we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata <= '0;
    else if (ce && re)  rdata <= rdata_n;
  end

  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce || !re) |=> $stable(rdata)); // R4

endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv_ld,
  input  logic              rd_wr_n,
  input  logic [LANES-1:0]  bwe_n,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic ce, sel;
  assign ce  = ~cen_n;
  assign sel = ~ce1_n & ce2 & ~ce3_n;

  // command issue
  logic              c_vld, c_rd;
  logic [LANES-1:0]  c_be;
  logic [ADDR_W-1:0] c_addr;

  zbt_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk     (clk),
    .rst_n   (rst_q),
    .ce      (ce),
    .adv     (adv_ld),
    .sel     (sel),
    .rd_in   (rd_wr_n),
    .be_in   (~bwe_n),
    .addr_in (addr),
    .linear  (burst_lin),
    .cmd_vld (c_vld),
    .cmd_rd  (c_rd),
    .cmd_be  (c_be),
    .cmd_addr(c_addr)
  );

  // two pipeline stages
  logic              s1_vld, s1_rd, s2_vld, s2_rd;
  logic [LANES-1:0]  s1_be, s2_be;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic              s1_vld_n, s1_rd_n, s2_vld_n, s2_rd_n;
  logic [LANES-1:0]  s1_be_n, s2_be_n;
  logic [ADDR_W-1:0] s1_addr_n, s2_addr_n;

  always_comb begin
    s1_vld_n  = c_vld;
    s1_rd_n   = c_rd;
    s1_be_n   = c_be;
    s1_addr_n = c_addr;
    s2_vld_n  = s1_vld;
    s2_rd_n   = s1_rd;
    s2_be_n   = s1_be;
    s2_addr_n = s1_addr;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_vld  <= 1'b0;
      s1_rd   <= 1'b0;
      s1_be   <= '0;
      s1_addr <= '0;
      s2_vld  <= 1'b0;
      s2_rd   <= 1'b0;
      s2_be   <= '0;
      s2_addr <= '0;
    end else if (ce) begin
      s1_vld  <= s1_vld_n;
      s1_rd   <= s1_rd_n;
      s1_be   <= s1_be_n;
      s1_addr <= s1_addr_n;
      s2_vld  <= s2_vld_n;
      s2_rd   <= s2_rd_n;
      s2_be   <= s2_be_n;
      s2_addr <= s2_addr_n;
    end
  end

  // storage: one array per byte lane
  logic [WORD_W-1:0] arr_rdata;
  logic              rd_issue;
  assign rd_issue = s1_vld & s1_rd;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic lane_we;
    assign lane_we = s2_vld & ~s2_rd & s2_be[j];
    zbt_lane_ram #(.ADDR_W(ADDR_W), .W(LANE_W)) u_lane (
      .clk  (clk),
      .rst_n(rst_q),
      .ce   (ce),
      .we   (lane_we),
      .waddr(s2_addr),
      .wdata(dq_in[j*LANE_W +: LANE_W]),
      .re   (rd_issue),
      .raddr(s1_addr),
      .rdata(arr_rdata[j*LANE_W +: LANE_W])
    );
  end

  // output register
  logic              out_vld_q, out_vld_n;
  logic [WORD_W-1:0] out_q, out_n;

  always_comb begin
    out_vld_n = s2_vld & s2_rd;
    out_n     = out_q;
    if (s2_vld && s2_rd) out_n = arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_vld_q <= 1'b0;
      out_q     <= '0;
    end else if (ce) begin
      out_vld_q <= out_vld_n;
      out_q     <= out_n;
    end
  end

  assign dq_out = out_q;
  assign dq_oe  = out_vld_q & ~oe_n;

  AST_READ_LAUNCH: assert property (@(posedge clk) disable iff (!rst_q)
    (ce && s2_vld && s2_rd) |=> out_vld_q); // R1

  AST_WRITE_RELEASE: assert property (@(posedge clk) disable iff (!rst_q)
    (ce && !(s2_vld && s2_rd)) |=> !out_vld_q); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !ce |=> ($stable(out_vld_q) && $stable(out_q) && $stable(s1_vld) && $stable(s2_vld))); // R4

  AST_DESEL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_q)
    (ce && !adv_ld && !sel) |=> !s1_vld); // R5

endmodule

// File: tb/tb_zbt_sram.sv
`timescale 1ns/1ps
module tb_zbt_sram;

  localparam int AW = 8;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n, cen_n, ce1_n, ce2, ce3_n, adv_ld, rd_wr_n, burst_lin, oe_n;
  logic [3:0]  bwe_n;
  logic [AW-1:0] addr;
  logic [35:0] dq_in, dq_out;
  logic        dq_oe;

  always #5 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) dut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .adv_ld(adv_ld), .rd_wr_n(rd_wr_n), .bwe_n(bwe_n),
    .burst_lin(burst_lin), .addr(addr), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int    total = 0, bad = 0;
  bit    done = 0;
  string tag = "R8";

  // reference state
  logic [35:0] refm [NW];
  logic        b_act, b_rd;
  logic [AW-1:0] b_base;
  logic [1:0]  b_n;
  logic        p1_v, p1_r, p2_v, p2_r;
  logic [3:0]  p1_be, p2_be;
  logic [AW-1:0] p1_a, p2_a;
  logic        e_vld;
  logic [35:0] e_data;

  task automatic check(input logic ok, input string t, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic logic [1:0] next_low(input logic [1:0] b, input logic [1:0] n, input logic lin);
    logic [1:0] s;
    s = lin ? 2'((b + n) & 2'b11) : (b ^ n);
    return s;
  endfunction

  task automatic model_edge(input logic desel, input logic adv, input logic rd,
                            input logic [3:0] bw, input logic [AW-1:0] a);
    logic n_v, n_r;
    logic [AW-1:0] n_a;
    n_v = 0; n_r = 0; n_a = '0;
    if (!adv) begin
      if (!desel) begin
        n_v = 1; n_r = rd; n_a = a;
        b_act = 1; b_rd = rd; b_base = a; b_n = 0;
      end else b_act = 0;
    end else if (b_act) begin
      b_n = b_n + 2'd1;
      n_v = 1; n_r = b_rd;
      n_a = {b_base[AW-1:2], next_low(b_base[1:0], b_n, burst_lin)};
    end
    if (p2_v && !p2_r)
      for (int j = 0; j < 4; j++)
        if (p2_be[j]) refm[p2_a][j*9 +: 9] = dq_in[j*9 +: 9];
    e_vld  = p2_v && p2_r;
    if (e_vld) e_data = refm[p2_a];
    p2_v = p1_v; p2_r = p1_r; p2_be = p1_be; p2_a = p1_a;
    p1_v = n_v;  p1_r = n_r;  p1_be = ~bw;   p1_a = n_a;
  endtask

  // one clock: drive at the falling edge, check 2 ns after the rising edge
  task automatic cyc(input logic i_cen_n, input logic desel, input logic adv,
                     input logic rd, input logic [3:0] bw, input logic [AW-1:0] a,
                     input logic i_oe_n);
    cen_n = i_cen_n; adv_ld = adv; rd_wr_n = rd; bwe_n = bw; addr = a; oe_n = i_oe_n;
    if (desel) begin
      case ($urandom % 3)
        0:       {ce1_n, ce2, ce3_n} = 3'b110;
        1:       {ce1_n, ce2, ce3_n} = 3'b000;
        default: {ce1_n, ce2, ce3_n} = 3'b011;
      endcase
    end else {ce1_n, ce2, ce3_n} = 3'b010;
    dq_in = {$urandom, $urandom};
    if (!i_cen_n) model_edge(desel, adv, rd, bw, a);
    @(posedge clk);
    #2;
    check(dq_oe === (e_vld & ~i_oe_n), {tag, " R1 R9 bus-enable"}, {35'd0, dq_oe}, {35'd0, e_vld & ~i_oe_n});
    if (e_vld) check(dq_out === e_data, {tag, " read-data"}, dq_out, e_data);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 4'hF, '0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    b_act = 0; b_rd = 0; b_base = '0; b_n = 0;
    p1_v = 0; p1_r = 0; p1_be = 0; p1_a = '0;
    p2_v = 0; p2_r = 0; p2_be = 0; p2_a = '0;
    e_vld = 0; e_data = '0;
    rst_n = 0; cen_n = 0; {ce1_n, ce2, ce3_n} = 3'b110; adv_ld = 0; rd_wr_n = 0;
    bwe_n = 4'hF; burst_lin = 1; addr = '0; oe_n = 0; dq_in = '0;
    repeat (3) @(negedge clk);
    check(dq_oe === 1'b0, "R8 reset drive", {35'd0, dq_oe}, 36'd0);
    rst_n = 1;
    // R8: an advance straight after reset must issue nothing
    tag = "R8 advance-after-reset";
    idle(3);
    cyc(0, 0, 1, 1, 4'h0, '0, 0);
    idle(2);

    // fill the whole array with full-word writes
    tag = "R2 fill";
    for (int i = 0; i < NW; i++) cyc(0, 0, 0, 0, 4'h0, AW'(i), 0);
    idle(2);

    // R3: write then read of the same word on the next edge, then read then write
    tag = "R3 write-read back-to-back";
    cyc(0, 0, 0, 0, 4'h0, 8'd5, 0);
    cyc(0, 0, 0, 1, 4'hF, 8'd5, 0);
    cyc(0, 0, 0, 0, 4'h0, 8'd5, 0);
    cyc(0, 0, 0, 1, 4'hF, 8'd5, 0);
    cyc(0, 0, 0, 1, 4'hF, 8'd5, 0);
    idle(3);

    // R2: lanes 0 and 2 written, lanes 1 and 3 kept
    tag = "R2 partial lanes";
    cyc(0, 0, 0, 0, 4'b1010, 8'd9, 0);
    idle(2);
    cyc(0, 0, 0, 1, 4'hF, 8'd9, 0);
    idle(3);

    // R6: bursts from base 5, linear 5,6,7,4 then interleaved 5,4,7,6
    tag = "R6 linear burst";
    burst_lin = 1;
    cyc(0, 0, 0, 1, 4'hF, 8'd5, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 4'hF, '0, 0);
    idle(3);
    tag = "R6 interleaved burst";
    burst_lin = 0;
    cyc(0, 0, 0, 1, 4'hF, 8'd5, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 4'hF, '0, 0);
    idle(3);
    tag = "R6 write burst";
    cyc(0, 0, 0, 0, 4'h0, 8'd20, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 4'b0101, '0, 0);
    idle(2);
    cyc(0, 0, 0, 1, 4'hF, 8'd20, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 4'hF, '0, 0);
    idle(3);

    // R5: deselect in mid burst, later advances do nothing
    tag = "R5 deselect stops burst";
    burst_lin = 1;
    cyc(0, 0, 0, 1, 4'hF, 8'd40, 0);
    cyc(0, 0, 1, 0, 4'hF, '0, 0);
    cyc(0, 1, 0, 0, 4'hF, '0, 0);
    cyc(0, 0, 1, 0, 4'hF, '0, 0);
    cyc(0, 0, 1, 0, 4'hF, '0, 0);
    idle(3);

    // R4: stalls with reads in flight and on the bus
    tag = "R4 clock-enable stall";
    cyc(0, 0, 0, 1, 4'hF, 8'd7, 0);
    cyc(0, 0, 0, 1, 4'hF, 8'd8, 0);
    cyc(1, 0, 0, 0, 4'h0, 8'd7, 0);
    cyc(0, 0, 0, 0, 4'h0, 8'd8, 0);
    cyc(1, 0, 1, 0, 4'h0, 8'd8, 0);
    cyc(1, 1, 0, 0, 4'h0, 8'd8, 0);
    cyc(0, 0, 0, 1, 4'hF, 8'd8, 0);
    idle(4);

    // R7: output enable acts between edges and leaves the data intact
    tag = "R7 output enable";
    cyc(0, 0, 0, 1, 4'hF, 8'd3, 0);
    idle(2);
    check(dq_oe === 1'b1, "R1 read window open", {35'd0, dq_oe}, 36'd1);
    oe_n = 1; #1;
    check(dq_oe === 1'b0, "R7 async release", {35'd0, dq_oe}, 36'd0);
    oe_n = 0; #1;
    check(dq_oe === 1'b1 && dq_out === refm[8'd3], "R7 data kept", dq_out, refm[8'd3]);
    @(negedge clk);
    idle(3);

    // random mix
    tag = "R1 R2 R3 R4 R5 R6 random";
    for (int i = 0; i < 4000; i++) begin
      logic s, d, v, r, o;
      logic [3:0] bw;
      if (i % 700 == 0) burst_lin = $urandom % 2;
      s  = ($urandom % 10) == 0;
      d  = ($urandom % 10) == 0;
      v  = ($urandom % 100) < 45;
      r  = $urandom % 2;
      o  = ($urandom % 20) == 0;
      bw = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      cyc(s, d, v, r, bw, AW'($urandom), o);
    end
    idle(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule